// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup and Dual Select

This block holds renamed instructions until their operands are available and then hands them to execution, oldest first and up to two per cycle. Each instruction arrives with an opcode, an optional destination physical tag and two source operands. A source is either a physical tag with a ready flag, or an immediate value, which counts as ready from the moment it is written.

Every cycle the queue picks up to two entries whose sources are both ready and drives them onto the issue outputs. Their slots are released at the next clock edge. The destination tags of the picked instructions are compared against every waiting source in the queue. A match marks that source ready, so a dependent instruction can issue in the very next cycle. Instructions that write no register, such as stores and branches, wake nothing.

Up to two new instructions can be written per cycle. The queue raises a stall flag when fewer than two slots are free. A flush empties the queue in one cycle.

Top module: `iq_sched`

## Requirements
- R1: After reset the queue is empty: `full` is low and no issue output is valid.
- R2: An entry whose two sources are ready at insertion issues in the next cycle. A source flagged immediate (`ins_imm` bit = 1) is ready regardless of `ins_rdy`, and its 16-bit field appears unchanged on `iss_fld`. Opcode and destination are passed through to the issue outputs.
- R3: At most two entries issue per cycle, chosen oldest first by insertion order. Port 0 is older than port 1 when both insert in the same cycle. Issue slot 0 carries the older pick, and `iss_valid[1]` is high only when `iss_valid[0]` is high.
- R4: An issued entry leaves the queue at the following edge and never issues again.
- R5: An issued entry with `iss_has_dst` = 1 broadcasts its destination tag, which is compared with the low 6 bits of every non-immediate waiting source. A matching source becomes ready, and its entry can issue in the cycle after the producer issued.
- R6: An instruction inserted in the same cycle as a broadcast of one of its source tags captures that source as ready.
- R7: An issued entry with `iss_has_dst` = 0 wakes no source, whatever its destination field holds.
- R8: `full` is high whenever fewer than two slots are free. Inserts presented while `full` is high are discarded.
- R9: While `flush` is high no issue output is valid and inserts are discarded. At the next edge every entry is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Remove all entries |
| ins_valid | input | 2 | Insert request per port |
| ins_op | input | 2x5 | Opcode per port |
| ins_has_dst | input | 2 | Instruction writes a register |
| ins_dst | input | 2x6 | Destination physical tag |
| ins_imm | input | 2x2 | Per port, per source: source is an immediate |
| ins_fld | input | 2x2x16 | Per source: tag in low 6 bits, or immediate value |
| ins_rdy | input | 2x2 | Per source: tag already ready |
| full | output | 1 | Fewer than two slots free; inserts stall |
| iss_valid | output | 2 | Issue slot valid (slot 0 oldest) |
| iss_op | output | 2x5 | Issued opcode |
| iss_has_dst | output | 2 | Issued instruction writes a register |
| iss_dst | output | 2x6 | Issued destination tag (also the broadcast tag) |
| iss_fld | output | 2x2x16 | Issued source fields |

## Verification
The hardest state to reach from the ports is one where age order and slot order disagree. In that state an older entry sits in a higher-numbered slot than a younger one, and both are woken by the same broadcast. The bench builds it by letting a short-lived instruction free slot 0 after two waiters have claimed higher slots, then placing a younger waiter in slot 0. A single producer then wakes all three at once. The same-cycle capture of a broadcast by a new instruction is reached by inserting the consumer on the exact cycle its producer is on the issue outputs.

// File: rtl/iq_sched.sv
module iq_sched #(
  parameter int ENTRIES = 16,
  parameter int OPW     = 5,
  parameter int TAGW    = 6,
  parameter int FLDW    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [1:0]                    ins_valid,
  input  logic [1:0][OPW-1:0]           ins_op,
  input  logic [1:0]                    ins_has_dst,
  input  logic [1:0][TAGW-1:0]          ins_dst,
  input  logic [1:0][1:0]               ins_imm,
  input  logic [1:0][1:0][FLDW-1:0]     ins_fld,
  input  logic [1:0][1:0]               ins_rdy,
  output logic                          full,
  output logic [1:0]                    iss_valid,
  output logic [1:0][OPW-1:0]           iss_op,
  output logic [1:0]                    iss_has_dst,
  output logic [1:0][TAGW-1:0]          iss_dst,
  output logic [1:0][1:0][FLDW-1:0]     iss_fld
);
  localparam int IDXW = $clog2(ENTRIES);
  localparam int CNTW = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0]    busy;
  logic [OPW-1:0]        e_op   [ENTRIES];
  logic                  e_hasd [ENTRIES];
  logic [TAGW-1:0]       e_dst  [ENTRIES];
  logic [1:0]            e_imm  [ENTRIES];
  logic [1:0][FLDW-1:0]  e_fld  [ENTRIES];
  logic [1:0]            e_rdy  [ENTRIES];
  logic [IDXW-1:0]       e_rank [ENTRIES];

  logic [ENTRIES-1:0] ready_v, hit;
  logic [1:0]         older_iss [ENTRIES];
  logic [IDXW-1:0]    pick0, pick1, slot_a, slot_b;
  logic               pick0_v, pick1_v;
  logic [CNTW-1:0]    nfree, survivors;
  logic [1:0]         acc, bc_v;
  logic [1:0][TAGW-1:0] bc_tag;
  logic [IDXW-1:0]    dst_slot [2];
  logic [IDXW-1:0]    new_rank [2];

  always_comb
    for (int i = 0; i < ENTRIES; i++) ready_v[i] = busy[i] & (&e_rdy[i]);

  // oldest-first select: rank 0 is the oldest live entry
  always_comb begin
    pick0 = '0; pick0_v = 1'b0;
    pick1 = '0; pick1_v = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (ready_v[i] && (!pick0_v || e_rank[i] < e_rank[pick0])) begin
        pick0 = IDXW'(i); pick0_v = 1'b1;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (ready_v[i] && pick0 != IDXW'(i) && (!pick1_v || e_rank[i] < e_rank[pick1])) begin
        pick1 = IDXW'(i); pick1_v = 1'b1;
      end
  end

  assign iss_valid      = {pick1_v, pick0_v} & {2{~flush}};
  assign iss_op[0]      = e_op[pick0];
  assign iss_op[1]      = e_op[pick1];
  assign iss_has_dst[0] = e_hasd[pick0];
  assign iss_has_dst[1] = e_hasd[pick1];
  assign iss_dst[0]     = e_dst[pick0];
  assign iss_dst[1]     = e_dst[pick1];
  assign iss_fld[0]     = e_fld[pick0];
  assign iss_fld[1]     = e_fld[pick1];
  assign bc_v           = iss_valid & iss_has_dst;
  assign bc_tag         = iss_dst;

  function automatic logic wake(input logic imm, input logic [FLDW-1:0] f);
    return !imm && ((bc_v[0] && f[TAGW-1:0] == bc_tag[0]) ||
                    (bc_v[1] && f[TAGW-1:0] == bc_tag[1]));
  endfunction

  always_comb
    for (int i = 0; i < ENTRIES; i++) begin
      hit[i] = (iss_valid[0] && pick0 == IDXW'(i)) || (iss_valid[1] && pick1 == IDXW'(i));
      older_iss[i] = 2'((iss_valid[0] && e_rank[pick0] < e_rank[i]) ? 1 : 0)
                   + 2'((iss_valid[1] && e_rank[pick1] < e_rank[i]) ? 1 : 0);
    end

  // free slot search: two lowest free indices
  always_comb begin
    nfree = '0; slot_a = '0; slot_b = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!busy[i]) begin
        slot_b = slot_a; slot_a = IDXW'(i);
      end
    for (int i = 0; i < ENTRIES; i++) nfree = nfree + CNTW'(!busy[i]);
  end

  assign full        = nfree < CNTW'(2);
  assign acc         = ins_valid & {2{~full & ~flush}};
  assign survivors   = CNTW'(ENTRIES) - nfree - CNTW'(iss_valid[0]) - CNTW'(iss_valid[1]);
  assign dst_slot[0] = slot_a;
  assign dst_slot[1] = acc[0] ? slot_b : slot_a;
  assign new_rank[0] = IDXW'(survivors);
  assign new_rank[1] = IDXW'(survivors) + IDXW'(acc[0]);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (hit[i]) busy[i] <= 1'b0;
        else if (busy[i]) begin
          e_rank[i] <= e_rank[i] - IDXW'(older_iss[i]);
          for (int s = 0; s < 2; s++)
            if (wake(e_imm[i][s], e_fld[i][s])) e_rdy[i][s] <= 1'b1;
        end
      end
      for (int p = 0; p < 2; p++)
        if (acc[p]) begin
          busy[dst_slot[p]]   <= 1'b1;
          e_op[dst_slot[p]]   <= ins_op[p];
          e_hasd[dst_slot[p]] <= ins_has_dst[p];
          e_dst[dst_slot[p]]  <= ins_dst[p];
          e_imm[dst_slot[p]]  <= ins_imm[p];
          e_fld[dst_slot[p]]  <= ins_fld[p];
          e_rank[dst_slot[p]] <= new_rank[p];
          for (int s = 0; s < 2; s++)
            e_rdy[dst_slot[p]][s] <= ins_imm[p][s] | ins_rdy[p][s] |
                                     wake(ins_imm[p][s], ins_fld[p][s]);
        end
    end
  end

  assert_empty_after_reset_R1: assert property (@(posedge clk) !rst_n |=> busy == '0);
  assert_slot_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> iss_valid[0] && pick0 != pick1);
  assert_issued_freed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |=> !busy[$past(pick0)]);
  assert_no_growth_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $countones(busy) <= $past($countones(busy)));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> busy == '0);
  assert_flush_blocks_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> iss_valid == 2'b00);
endmodule

// File: tb/iq_sched_tb_top.sv
module iq_sched_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [1:0] ins_valid, ins_has_dst;
  logic [1:0][4:0] ins_op;
  logic [1:0][5:0] ins_dst;
  logic [1:0][1:0] ins_imm, ins_rdy;
  logic [1:0][1:0][15:0] ins_fld;
  logic full;
  logic [1:0] iss_valid, iss_has_dst;
  logic [1:0][4:0] iss_op;
  logic [1:0][5:0] iss_dst;
  logic [1:0][1:0][15:0] iss_fld;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iq_sched dut_i (.clk, .rst_n, .flush, .ins_valid, .ins_op, .ins_has_dst, .ins_dst,
                  .ins_imm, .ins_fld, .ins_rdy, .full, .iss_valid, .iss_op,
                  .iss_has_dst, .iss_dst, .iss_fld);

  typedef struct packed {
    logic v; logic [5:0] dst;
    logic i1; logic [5:0] t1; logic r1;
    logic i2; logic [5:0] t2; logic r2;
    logic [1:0] ecnt; logic [5:0] edst;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 6'd10, 1'b1, 6'd0,  1'b0, 1'b1, 6'd0,  1'b0, 2'd0, 6'd0},
    '{1'b1, 6'd11, 1'b0, 6'd10, 1'b0, 1'b1, 6'd0,  1'b0, 2'd1, 6'd10},
    '{1'b1, 6'd12, 1'b0, 6'd20, 1'b0, 1'b0, 6'd21, 1'b0, 2'd1, 6'd11},
    '{1'b1, 6'd20, 1'b1, 6'd0,  1'b0, 1'b1, 6'd0,  1'b0, 2'd0, 6'd0},
    '{1'b1, 6'd21, 1'b1, 6'd0,  1'b0, 1'b1, 6'd0,  1'b0, 2'd1, 6'd20},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b0, 2'd1, 6'd21},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b0, 2'd1, 6'd12},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b0, 2'd0, 6'd0}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clr();
    ins_valid = '0; ins_op = '0; ins_has_dst = '0; ins_dst = '0;
    ins_imm = '0; ins_fld = '0; ins_rdy = '0;
  endtask

  task automatic put(input int p, input int op, input bit hd, input int dst,
                     input bit i1, input int f1, input bit r1,
                     input bit i2, input int f2, input bit r2);
    ins_valid[p] = 1'b1; ins_op[p] = 5'(op); ins_has_dst[p] = hd; ins_dst[p] = 6'(dst);
    ins_imm[p] = {i2, i1}; ins_rdy[p] = {r2, r1};
    ins_fld[p][0] = 16'(f1); ins_fld[p][1] = 16'(f2);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); clr();
  endtask

  function automatic int cnt();
    return int'(iss_valid[0]) + int'(iss_valid[1]);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 full", int'(full), 0);
    chk("R1 issue", int'(iss_valid), 0);

    // R2 R5 R6: dependence chain from the vector table
    foreach (VEC[k]) begin
      chk("R5 count", cnt(), int'(VEC[k].ecnt));
      if (VEC[k].ecnt != 0) chk("R6 dst", int'(iss_dst[0]), int'(VEC[k].edst));
      if (VEC[k].v)
        put(0, 1, 1'b1, int'(VEC[k].dst), VEC[k].i1, int'(VEC[k].t1), VEC[k].r1,
            VEC[k].i2, int'(VEC[k].t2), VEC[k].r2);
      tick();
    end

    // R3: age order differs from slot order
    put(0, 2, 1'b0, 0, 1'b1, 0, 1'b0, 1'b1, 0, 1'b0);
    put(1, 3, 1'b1, 33, 1'b0, 40, 1'b0, 1'b1, 0, 1'b0);
    tick();
    chk("R2 nodst issue", cnt(), 1);
    chk("R2 nodst flag", int'(iss_has_dst[0]), 0);
    put(0, 3, 1'b1, 34, 1'b0, 40, 1'b0, 1'b1, 0, 1'b0);
    tick();
    chk("R4 no reissue", cnt(), 0);
    put(0, 3, 1'b1, 35, 1'b0, 40, 1'b0, 1'b1, 0, 1'b0);
    tick();
    put(0, 5, 1'b1, 40, 1'b1, 7, 1'b0, 1'b1, 9, 1'b0);
    tick();
    chk("R2 producer", cnt(), 1);
    chk("R2 op", int'(iss_op[0]), 5);
    chk("R2 imm field", int'(iss_fld[0][0]), 7);
    chk("R2 dst", int'(iss_dst[0]), 40);
    tick();
    chk("R3 dual", cnt(), 2);
    chk("R3 oldest", int'(iss_dst[0]), 33);
    chk("R3 second", int'(iss_dst[1]), 34);
    tick();
    chk("R3 youngest", cnt(), 1);
    chk("R3 youngest dst", int'(iss_dst[0]), 35);
    tick();
    chk("R4 drained", cnt(), 0);

    // R7: no-destination instruction wakes nothing
    put(0, 4, 1'b0, 41, 1'b1, 0, 1'b0, 1'b1, 0, 1'b0);
    put(1, 3, 1'b1, 42, 1'b0, 41, 1'b0, 1'b1, 0, 1'b0);
    tick();
    chk("R7 store issues", cnt(), 1);
    tick();
    chk("R7 no wake", cnt(), 0);

    // R9: flush drops pending and same-cycle inserts
    flush = 1'b1;
    put(0, 3, 1'b1, 43, 1'b1, 0, 1'b0, 1'b1, 0, 1'b0);
    tick();
    flush = 1'b0;
    chk("R9 insert dropped", cnt(), 0);
    put(0, 3, 1'b1, 44, 1'b1, 0, 1'b0, 1'b1, 0, 1'b0);
    tick();
    flush = 1'b1;
    #1;
    chk("R9 issue blocked", cnt(), 0);
    tick();
    flush = 1'b0;
    chk("R9 entry gone", cnt(), 0);

    // R8: fill to the stall point
    for (int k = 0; k < 7; k++) begin
      put(0, 6, 1'b1, 2 * k, 1'b0, 63, 1'b0, 1'b1, 0, 1'b0);
      put(1, 6, 1'b1, 2 * k + 1, 1'b0, 63, 1'b0, 1'b1, 0, 1'b0);
      tick();
    end
    chk("R8 two free", int'(full), 0);
    put(0, 6, 1'b1, 14, 1'b0, 63, 1'b0, 1'b1, 0, 1'b0);
    tick();
    chk("R8 full", int'(full), 1);
    put(0, 3, 1'b1, 45, 1'b1, 0, 1'b0, 1'b1, 0, 1'b0);
    put(1, 3, 1'b1, 46, 1'b1, 0, 1'b0, 1'b1, 0, 1'b0);
    tick();
    chk("R8 insert ignored", cnt(), 0);
    chk("R8 still full", int'(full), 1);
    flush = 1'b1;
    tick();
    flush = 1'b0;
    chk("R9 full cleared", int'(full), 0);
    put(0, 3, 1'b1, 63, 1'b1, 0, 1'b0, 1'b1, 0, 1'b0);
    tick();
    chk("R9 producer only", cnt(), 1);
    chk("R9 producer dst", int'(iss_dst[0]), 63);
    tick();
    chk("R9 waiters flushed", cnt(), 0);

    summary();
  end
endmodule